// File: doc/BRIEF.md
# Four-Channel DMA Request Arbiter

This block chooses which of four DMA channels may run its next transfer. Each channel raises a request line. When the block is idle and not halted, it picks one requester, drives a one-hot grant with a valid strobe, and holds that grant until the channel pulses transfer-done. The block then spends one idle cycle and arbitrates again.

Software selects one of four ordering policies through a single control register. Three of them are fixed rankings, and they are deliberately not monotonic in channel number. The fourth rotates priority among the channels. The same register holds an address-error flag. An address-error input sets this flag. While the flag is set, the block withdraws every grant and drives a level error interrupt. Software can drop the flag only by reading it as 1 and then writing 0 to it.

Top module: `dma_chan_arbiter`

## Requirements
- R1: After reset, grant is 0000, grant_vld is 0, err_irq is 0 and reg_rdata reads 0.
- R2: With mode field 00, simultaneous requests are served in the order channel 0, 1, 2, 3 (channel 0 highest).
- R3: With mode field 01, the order is channel 0, then 2, then 3, then 1.
- R4: With mode field 10, the order is channel 2, then 0, then 1, then 3.
- R5: With mode field 11, priority rotates. The channel after the most recently granted one (in any mode) is highest, continuing cyclically. The most recently granted channel counts as channel 3 after reset, so channel 0 leads first.
- R6: A single active request is granted in every mode.
- R7: A grant appears on the cycle after the request is sampled in the idle state. It stays unchanged whatever the requests do until xfer_done is seen high. The next cycle is idle, and arbitration resumes on the one after.
- R8: A cycle with addr_err high sets the error flag (register bit 4) on the next edge. err_irq equals the flag. While the flag is 1, grant is 0000 and grant_vld is 0, and a grant in progress is withdrawn in the same cycle the flag rises.
- R9: Writing 1 to bit 4 never sets the flag. Writing 0 to bit 4 leaves a set flag unchanged unless a read strobe has returned the flag as 1 since it was last set.
- R10: After a read strobe that returns bit 4 = 1, a write with bit 4 = 0 clears the flag, and grants resume.
- R11: If addr_err is high in the same cycle as a write that would clear the flag, the flag stays set.
- R12: The register holds the mode in bits 1:0 and the flag in bit 4. Every other bit reads 0 whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 4 | Request line per channel |
| xfer_done | input | 1 | One-cycle pulse ending the granted transfer |
| addr_err | input | 1 | Address error event |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (arms the flag clear) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational |
| grant | output | 4 | One-hot grant |
| grant_vld | output | 1 | A grant is active |
| err_irq | output | 1 | Error interrupt, level |

## Verification
If the rotation pointer holds a wrong value, it shows up only in rotating mode, on the first grant where two or more channels compete, one cycle after the requests are sampled. A wrong ranking table shows up on that same grant cycle. If the armed bit is stale, the flag clears too early or fails to clear, and err_irq shows this on the edge after the write. The scoreboard compares every grant event against an independent ordering model, so a single misplaced grant is caught at the moment it rises.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int NCH = 4;
  localparam int CW  = 2;

  typedef enum logic [1:0] {
    PM_FIX_A  = 2'b00,
    PM_FIX_B  = 2'b01,
    PM_FIX_C  = 2'b10,
    PM_ROTATE = 2'b11
  } prio_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_HOLD = 1'b1
  } gnt_state_e;

  // Channel at a given rank; rank 0 is in the low bits.
  function automatic logic [CW-1:0] fixed_rank(input prio_mode_e m, input int r);
    logic [NCH*CW-1:0] tbl;
    case (m)
      PM_FIX_B: tbl = 8'b01_11_10_00;
      PM_FIX_C: tbl = 8'b11_01_00_10;
      default:  tbl = 8'b11_10_01_00;
    endcase
    return tbl[CW*r +: CW];
  endfunction
endpackage

// File: rtl/arb_ctrl_reg.sv
module arb_ctrl_reg
  import dma_arb_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int MODE_LSB = 0,
  parameter int AE_BIT   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [DATA_W-1:0] wdata,
  input  logic              addr_err,
  output logic [DATA_W-1:0] rdata,
  output prio_mode_e        mode,
  output logic              ae
);
  prio_mode_e mode_q, mode_d;
  logic ae_q, ae_d, armed_q, armed_d, clr_req;
  logic unused_wbits;

  assign unused_wbits = ^wdata;

  always_comb begin
    mode_d  = wr ? prio_mode_e'(wdata[MODE_LSB +: CW]) : mode_q;
    clr_req = wr && !wdata[AE_BIT] && armed_q;
    ae_d    = ae_q;
    armed_d = armed_q;
    if (addr_err) begin
      ae_d    = 1'b1;
      armed_d = 1'b0;
    end else if (clr_req) begin
      ae_d    = 1'b0;
      armed_d = 1'b0;
    end else if (rd && ae_q) begin
      armed_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= PM_FIX_A;
      ae_q    <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      ae_q    <= ae_d;
      armed_q <= armed_d;
    end
  end

  always_comb begin
    rdata                     = '0;
    rdata[MODE_LSB +: CW]     = mode_q;
    rdata[AE_BIT]             = ae_q;
  end

  assign mode = mode_q;
  assign ae   = ae_q;
endmodule

// File: rtl/arb_select.sv
module arb_select
  import dma_arb_pkg::*;
(
  input  logic [NCH-1:0] req,
  input  prio_mode_e     mode,
  input  logic [CW-1:0]  last,
  output logic [NCH-1:0] pick,
  output logic [CW-1:0]  pick_idx,
  output logic           any
);
  logic [CW-1:0] cand [NCH];

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_rank
      assign cand[g] = (mode == PM_ROTATE) ? CW'(last + CW'(g) + CW'(1))
                                           : fixed_rank(mode, g);
    end
  endgenerate

  always_comb begin
    pick     = '0;
    pick_idx = '0;
    any      = 1'b0;
    for (int r = 0; r < NCH; r++) begin
      if (!any && req[cand[r]]) begin
        pick[cand[r]] = 1'b1;
        pick_idx      = cand[r];
        any           = 1'b1;
      end
    end
  end
endmodule

// File: rtl/arb_grant_fsm.sv
module arb_grant_fsm
  import dma_arb_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           halt,
  input  logic           any,
  input  logic [NCH-1:0] pick,
  input  logic [CW-1:0]  pick_idx,
  input  logic           xfer_done,
  output logic [NCH-1:0] grant,
  output logic           grant_vld,
  output logic [CW-1:0]  last
);
  gnt_state_e     st_q, st_d;
  logic [NCH-1:0] gnt_q, gnt_d;
  logic [CW-1:0]  last_q;
  logic           last_en;

  always_comb begin
    st_d    = st_q;
    gnt_d   = gnt_q;
    last_en = 1'b0;
    case (st_q)
      ST_IDLE: if (!halt && any) begin
        st_d    = ST_HOLD;
        gnt_d   = pick;
        last_en = 1'b1;
      end
      default: if (halt || xfer_done) begin
        st_d  = ST_IDLE;
        gnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      gnt_q  <= '0;
      last_q <= CW'(NCH - 1);
    end else begin
      st_q  <= st_d;
      gnt_q <= gnt_d;
      if (last_en) last_q <= pick_idx;
    end
  end

  assign grant     = gnt_q & {NCH{~halt}};
  assign grant_vld = (st_q == ST_HOLD) && !halt;
  assign last      = last_q;
endmodule

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter
  import dma_arb_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    req,
  input  logic              xfer_done,
  input  logic              addr_err,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NCH-1:0]    grant,
  output logic              grant_vld,
  output logic              err_irq
);
  prio_mode_e     mode;
  logic           ae, any;
  logic [NCH-1:0] pick;
  logic [CW-1:0]  pick_idx, last;

  arb_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .wdata(reg_wdata),
    .addr_err(addr_err), .rdata(reg_rdata), .mode(mode), .ae(ae)
  );

  arb_select u_sel (
    .req(req), .mode(mode), .last(last),
    .pick(pick), .pick_idx(pick_idx), .any(any)
  );

  arb_grant_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .halt(ae), .any(any), .pick(pick),
    .pick_idx(pick_idx), .xfer_done(xfer_done),
    .grant(grant), .grant_vld(grant_vld), .last(last)
  );

  assign err_irq = ae;
endmodule

// File: rtl/dma_arb_chk.sv
module dma_arb_chk
  import dma_arb_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCH-1:0]    req,
  input logic              xfer_done,
  input logic              addr_err,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [NCH-1:0]    grant,
  input logic              grant_vld,
  input logic              err_irq
);
  logic unused_chk;
  assign unused_chk = reg_rd;

  logic idle_ok;
  assign idle_ok = !grant_vld && !err_irq && !addr_err;

  // R7
  grant_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld |-> $countones(grant) == 1);

  // R2
  mode_a_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_ok && reg_rdata[1:0] == 2'b00 && req[0] |=> grant == 4'b0001);

  // R4
  mode_c_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_ok && reg_rdata[1:0] == 2'b10 && req[2] |=> grant == 4'b0100);

  // R6
  lone_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_ok && $onehot(req) |=> grant == $past(req));

  // R7
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld && !xfer_done |=> (err_irq || $stable(grant)));

  // R8
  halt_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> (!grant_vld && grant == '0));

  // R9
  no_soft_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_wdata[4] && !addr_err && !err_irq |=> !err_irq);

  // R11
  err_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |=> err_irq);

  // R12
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DATA_W-1:5] == '0 && reg_rdata[3:2] == '0);
endmodule

bind dma_chan_arbiter dma_arb_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_dma_chan_arbiter.sv
module test_dma_chan_arbiter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  req;
  logic        xfer_done, addr_err, reg_wr, reg_rd;
  logic [15:0] reg_wdata, reg_rdata;
  logic [3:0]  grant;
  logic        grant_vld, err_irq;

  always #5 clk = ~clk;

  dma_chan_arbiter i_dma_chan_arbiter (
    .clk(clk), .rst_n(rst_n), .req(req), .xfer_done(xfer_done),
    .addr_err(addr_err), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .grant(grant),
    .grant_vld(grant_vld), .err_irq(err_irq)
  );

  int n_chk = 0;
  int n_err = 0;
  int last_m = 3;
  int mode_m = 0;
  bit finished = 0;
  logic [3:0] exp_q[$];
  string      tag_q[$];
  logic       vld_prev;

  task automatic chk(input string rq, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic int model(input int m, input logic [3:0] r, input int lst);
    int ord[3][4] = '{'{0, 1, 2, 3}, '{0, 2, 3, 1}, '{2, 0, 1, 3}};
    for (int k = 0; k < 4; k++) begin
      int c = (m == 3) ? (lst + 1 + k) % 4 : ord[m][k];
      if (r[c]) return c;
    end
    return -1;
  endfunction

  // monitor: compares each new grant with the scoreboard head
  always @(negedge clk) begin
    if (!rst_n) vld_prev <= 1'b0;
    else begin
      if (grant_vld && !vld_prev) begin
        if (exp_q.size() == 0) chk("R7 unexpected grant", {12'h0, grant}, 16'h0);
        else chk(tag_q.pop_front(), {12'h0, grant}, {12'h0, exp_q.pop_front()});
      end
      vld_prev <= grant_vld;
    end
  end

  task automatic push_exp(input logic [3:0] r, input string tag);
    int c = model(mode_m, r, last_m);
    exp_q.push_back(4'b0001 << c);
    tag_q.push_back(tag);
    last_m = c;
  endtask

  task automatic round(input logic [3:0] r, input string tag);
    push_exp(r, tag);
    req = r;
    @(negedge clk);
    xfer_done = 1'b1;
    req = 4'b0;
    @(negedge clk);
    xfer_done = 1'b0;
  endtask

  task automatic wr_reg(input logic [15:0] d);
    reg_wr = 1'b1;
    reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(output logic [15:0] v);
    reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic set_mode(input int m);
    wr_reg(16'(m));
    mode_m = m;
  endtask

  initial begin
    #(100000 * 10);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    rst_n = 1'b0; req = '0; xfer_done = 0; addr_err = 0;
    reg_wr = 0; reg_rd = 0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 grant", {12'h0, grant}, 16'h0);
    chk("R1 vld", {15'h0, grant_vld}, 16'h0);
    chk("R1 irq", {15'h0, err_irq}, 16'h0);
    chk("R1 rdata", reg_rdata, 16'h0);

    // R2 fixed order A
    round(4'b1111, "R2 all");
    round(4'b1110, "R2 no0");
    round(4'b1100, "R2 2v3");
    round(4'b1010, "R2 1v3");
    round(4'b1000, "R6 lone ch3 mode0");

    // R3 fixed order B
    set_mode(1);
    chk("R12 mode readback", reg_rdata, 16'h0001);
    round(4'b1111, "R3 all");
    round(4'b1110, "R3 no0");
    round(4'b1010, "R3 1v3");
    round(4'b0010, "R6 lone ch1 mode1");

    // R4 fixed order C
    set_mode(2);
    round(4'b1111, "R4 all");
    round(4'b1011, "R4 no2");
    round(4'b1010, "R4 1v3");
    round(4'b1000, "R6 lone ch3 mode2");

    // R5 rotation
    set_mode(3);
    for (int k = 0; k < 5; k++) round(4'b1111, "R5 all rotate");
    round(4'b1010, "R5 1v3");
    round(4'b1001, "R5 0v3");
    round(4'b0100, "R6 lone ch2 mode3");

    // R7 hold until done regardless of request changes
    push_exp(4'b1111, "R7 first");
    req = 4'b1111;
    @(negedge clk);
    req = 4'b0100;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R7 held", {12'h0, grant}, {12'h0, exp_q.size() == 0 ? (4'b0001 << last_m) : 4'b0});
    end
    xfer_done = 1'b1; req = 4'b0;
    @(negedge clk);
    xfer_done = 1'b0;
    chk("R7 released", {15'h0, grant_vld}, 16'h0);

    // R8 error withdraws grant
    push_exp(4'b0001, "R8 pre grant");
    req = 4'b0001;
    @(negedge clk);
    addr_err = 1'b1;
    @(negedge clk);
    addr_err = 1'b0;
    chk("R8 irq", {15'h0, err_irq}, 16'h1);
    chk("R8 grant withdrawn", {11'h0, grant_vld, grant}, 16'h0);
    chk("R8 flag bit", reg_rdata, 16'h0013);
    repeat (3) @(negedge clk);
    chk("R8 still blocked", {11'h0, grant_vld, grant}, 16'h0);
    req = 4'b0;

    // R9 write 1 / write 0 without read
    wr_reg(16'h0013);
    chk("R9 write1 keeps", {15'h0, err_irq}, 16'h1);
    wr_reg(16'h0003);
    chk("R9 clear without read", {15'h0, err_irq}, 16'h1);

    // R11 error wins over armed clear
    rd_reg(v);
    chk("R10 read sees flag", v & 16'h0010, 16'h0010);
    reg_wr = 1'b1; reg_wdata = 16'h0003; addr_err = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; addr_err = 1'b0;
    chk("R11 error wins", {15'h0, err_irq}, 16'h1);

    // R10 proper clear
    rd_reg(v);
    wr_reg(16'h0003);
    chk("R10 cleared", {15'h0, err_irq}, 16'h0);
    chk("R10 rdata", reg_rdata, 16'h0003);
    round(4'b0001, "R10 grants resume");

    // R12 reserved bits and R9 write1 while clear
    wr_reg(16'hFFFF);
    chk("R12 reserved zero", reg_rdata, 16'h0003);
    chk("R9 write1 no set", {15'h0, err_irq}, 16'h0);

    repeat (2) @(negedge clk);
    chk("R7 scoreboard drained", 16'(exp_q.size()), 16'h0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule